// File: doc/BRIEF.md
# Early-Read Memory with Two-Stage Write Forwarding

This block is a single-write, single-read storage array for pipelines that pass values from one stage to the next through memory and need a value written in one cycle to be readable in the very next one. The read address is presented one cycle before its data is consumed. The array read is therefore launched early, and the value appears on the output in the following cycle.

Writes are captured in a short history of registers before they reach the array. The array cannot return data it is writing on the same edge. So the two most recent writes are kept with their addresses and a valid flag. The delayed read address is compared against both entries, and a priority selector picks the newest matching entry, or the array output when neither entry matches. Seen from the ports, the block behaves like an ideal memory in which every write is visible to a read presented in the same cycle or in any later cycle.

Top module: `bp2_mem`

## Requirements
- R1: The value on `rd_data` in cycle r+1 is the content of the address presented on `rd_addr` in cycle r, for any mix of reads and writes.
- R2: A write presented in the same cycle as a read of the same address is visible to that read (write-first).
- R3: A write presented one cycle before a read of the same address is returned by that read.
- R4: A write presented two or more cycles before a read, with no newer write to that address, is returned from the array.
- R5: When several pending writes target the read address, the most recently presented one supplies the data.
- R6: A cycle with `wr_en` low changes neither the stored content nor the forwarded value, whatever `wr_addr` and `wr_data` carry.
- R7: While `rst_n` is low, `rd_data` is zero and no history entry can match.
- R8: The default widths are 16 data bits and 8 address bits, and the lowest and highest addresses (0 and 255) behave like any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read address, one cycle ahead of its data |
| rd_data | output | 16 | Read result for the address given in the previous cycle |

## Verification
The assertions assume that every input is known after reset and that the reads they judge target addresses with a defined content. Addresses never written hold no defined value. The forwarding properties only compare `rd_data` with write data that was seen on the ports, so they never depend on an unwritten location. The stimulus sets all inputs to zero during reset and only checks reads of addresses it has already written. It keeps the random traffic inside a small address window so that back-to-back writes to the same address, and reads that overlap them, occur often.

// File: rtl/bp2_pkg.sv
package bp2_pkg;
  // Number of write-history stages needed when the read is launched one
  // cycle early and the array is written one cycle after capture.
  localparam int HIST_DEPTH = 2;
  // Stage whose entry is committed into the array on the next edge.
  localparam int RAM_TAP    = HIST_DEPTH - 2;
endpackage

// File: rtl/bp2_ram.sv
module bp2_ram #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rdata_d;

  // Array write: no reset on storage, gated by the write enable.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Synchronous read: returns the old content on a same-edge write.
  always_comb begin
    rdata_d = mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/bp2_hist.sv
module bp2_hist #(
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_v,
  input  logic [AW-1:0]             in_a,
  input  logic [DW-1:0]             in_d,
  output logic [DEPTH-1:0]          h_v,
  output logic [DEPTH-1:0][AW-1:0]  h_a,
  output logic [DEPTH-1:0][DW-1:0]  h_d
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic          v_d;
    logic [AW-1:0] a_d;
    logic [DW-1:0] d_d;
    logic          v_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;

    if (s == 0) begin : g_head
      always_comb begin
        v_d = in_v;
        a_d = in_a;
        d_d = in_d;
      end
    end else begin : g_tail
      always_comb begin
        v_d = h_v[s-1];
        a_d = h_a[s-1];
        d_d = h_d[s-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else begin
        v_q <= v_d;
      end
    end

    // Payload loads only when the incoming entry is valid.
    always_ff @(posedge clk) begin
      if (v_d) begin
        a_q <= a_d;
        d_q <= d_d;
      end
    end

    assign h_v[s] = v_q;
    assign h_a[s] = a_q;
    assign h_d[s] = d_q;
  end
endmodule

// File: rtl/bp2_fwd.sv
module bp2_fwd #(
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int DEPTH = 2
) (
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             ram_q,
  input  logic [DEPTH-1:0]          h_v,
  input  logic [DEPTH-1:0][AW-1:0]  h_a,
  input  logic [DEPTH-1:0][DW-1:0]  h_d,
  output logic [DEPTH-1:0]          pick,
  output logic [DW-1:0]             data
);
  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = h_v[i] && (h_a[i] == addr);
    // Stage 0 is the newest entry; an older stage wins only if no newer hit.
    if (i == 0) begin : g_first
      assign pick[i] = hit[i];
    end else begin : g_rest
      assign pick[i] = hit[i] && !(|hit[i-1:0]);
    end
  end

  logic [DW-1:0] fwd_or;

  always_comb begin
    fwd_or = '0;
    for (int i = 0; i < DEPTH; i++) begin
      fwd_or = fwd_or | ({DW{pick[i]}} & h_d[i]);
    end
    data = (|pick) ? fwd_or : ram_q;
  end
endmodule

// File: rtl/bp2_mem.sv
module bp2_mem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  import bp2_pkg::*;

  localparam int DEPTH = HIST_DEPTH;

  logic [DEPTH-1:0]         h_v;
  logic [DEPTH-1:0][AW-1:0] h_a;
  logic [DEPTH-1:0][DW-1:0] h_d;
  logic [DEPTH-1:0]         pick_vec;
  logic [DW-1:0]            ram_q;
  logic [AW-1:0]            rd_addr_q;

  bp2_hist #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) i_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (wr_en),
    .in_a  (wr_addr),
    .in_d  (wr_data),
    .h_v   (h_v),
    .h_a   (h_a),
    .h_d   (h_d)
  );

  bp2_ram #(.DW(DW), .AW(AW)) i_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (h_v[RAM_TAP]),
    .waddr (h_a[RAM_TAP]),
    .wdata (h_d[RAM_TAP]),
    .raddr (rd_addr),
    .rdata (ram_q)
  );

  // Read address follows the early array read by one cycle for comparison.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
    end else begin
      rd_addr_q <= rd_addr;
    end
  end

  bp2_fwd #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) i_fwd (
    .addr  (rd_addr_q),
    .ram_q (ram_q),
    .h_v   (h_v),
    .h_a   (h_a),
    .h_d   (h_d),
    .pick  (pick_vec),
    .data  (rd_data)
  );
endmodule

// File: rtl/bp2_mem_chk.sv
module bp2_mem_chk #(
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int DEPTH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [AW-1:0]    rd_addr,
  input logic [DW-1:0]    rd_data,
  input logic [DEPTH-1:0] pick
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
    end else if (age != 2'd3) begin
      age <= age + 2'd1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (rd_data == '0 && pick == '0); // R7
    end
  end

  AST_SAME_CYCLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_addr) |=> (rd_data == $past(wr_data))); // R2

  AST_PREV_CYCLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(wr_en) && $past(wr_addr) == rd_addr
     && !(wr_en && wr_addr == rd_addr))
    |=> (rd_data == $past(wr_data, 2))); // R3

  AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !wr_en && rd_addr == $past(rd_addr)) |=> $stable(rd_data)); // R6
endmodule

bind bp2_mem bp2_mem_chk #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .pick    (pick_vec)
);

// File: tb/test_bp2_mem.sv
module test_bp2_mem;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int NA = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  logic [DW-1:0] ref_mem   [NA];
  logic          ref_known [NA];
  int checks;
  int errors;
  bit done;

  bp2_mem #(.DW(DW), .AW(AW)) i_bp2_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive inputs at a falling edge, sample the result of this
  // read at the next falling edge (after the capturing rising edge).
  task automatic step(string req, logic we, logic [AW-1:0] wa,
                      logic [DW-1:0] wd, logic [AW-1:0] ra);
    logic [DW-1:0] exp;
    logic          known;
    wr_en   = we;
    wr_addr = wa;
    wr_data = wd;
    rd_addr = ra;
    if (we) begin
      ref_mem[wa]   = wd;
      ref_known[wa] = 1'b1;
    end
    exp   = ref_mem[ra];
    known = ref_known[ra];
    @(posedge clk);
    @(negedge clk);
    if (known) chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    #(CLK_PERIOD*3);
    @(negedge clk);
    chk("R7 reset output", rd_data, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_ram_path;
    for (int i = 0; i < 8; i++) step("R4 fill", 1'b1, AW'(16 + i), DW'(16'hA000 + i*3), AW'(16 + i));
    step("R4 gap", 1'b0, '0, '0, 8'd200);
    step("R4 gap", 1'b0, '0, '0, 8'd200);
    for (int i = 0; i < 8; i++) step("R4 array read R1", 1'b0, '0, '0, AW'(16 + i));
  endtask

  task automatic t_same;
    step("R2 same cycle", 1'b1, 8'h40, 16'h1234, 8'h40);
    step("R2 overwrite same cycle", 1'b1, 8'h40, 16'h4321, 8'h40);
  endtask

  task automatic t_prev;
    step("R3 setup", 1'b1, 8'h41, 16'hBEEF, 8'h99);
    step("R3 prev cycle", 1'b1, 8'h42, 16'hCAFE, 8'h41);
    step("R3 prev cycle idle", 1'b0, 8'h42, 16'h0000, 8'h42);
  endtask

  task automatic t_newest;
    step("R5 a", 1'b1, 8'h50, 16'h0A0A, 8'h98);
    step("R5 both stages newest", 1'b1, 8'h50, 16'h0B0B, 8'h50);
    step("R5 a2", 1'b1, 8'h51, 16'h1111, 8'h98);
    step("R5 b2", 1'b1, 8'h51, 16'h2222, 8'h98);
    step("R5 older stage over array", 1'b0, '0, '0, 8'h51);
    step("R5 c", 1'b1, 8'h52, 16'h3333, 8'h98);
    step("R5 d", 1'b1, 8'h52, 16'h4444, 8'h98);
    step("R5 e", 1'b1, 8'h52, 16'h5555, 8'h98);
    step("R5 newest of three", 1'b0, '0, '0, 8'h52);
  endtask

  task automatic t_idle;
    step("R6 setup", 1'b1, 8'h60, 16'h6060, 8'h98);
    step("R6 disabled write ignored", 1'b0, 8'h60, 16'hDEAD, 8'h60);
    step("R6 disabled write stage1", 1'b0, 8'h60, 16'hDEAD, 8'h60);
    step("R6 disabled write array", 1'b0, 8'h61, 16'hDEAD, 8'h60);
  endtask

  task automatic t_edges;
    step("R8 low addr", 1'b1, 8'h00, 16'hFFFF, 8'h00);
    step("R8 high addr", 1'b1, 8'hFF, 16'h0000, 8'h00);
    step("R8 high prev", 1'b1, 8'hFF, 16'h8001, 8'hFF);
    step("R8 settle", 1'b0, '0, '0, 8'hFF);
    step("R8 low from array", 1'b0, '0, '0, 8'h00);
    step("R8 high from array", 1'b0, '0, '0, 8'hFF);
  endtask

  task automatic t_stream;
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R1 mixed traffic", lfsr[0] | lfsr[5], AW'(8'h70 + lfsr[3:1]),
           lfsr ^ 16'h5A5A, AW'(8'h70 + lfsr[9:7]));
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    for (int i = 0; i < NA; i++) begin
      ref_mem[i]   = '0;
      ref_known[i] = 1'b0;
    end
    t_reset();
    t_ram_path();
    t_same();
    t_prev();
    t_newest();
    t_idle();
    t_edges();
    t_stream();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule